// File: doc/BRIEF.md
# Three-Slot Scan Link to 4-Wire TAP Adapter

This block sits between a two-pin debug link and a conventional test access port. When the link runs the three-slot scan format, one bidirectional data wire carries, on three consecutive rising edges of the link clock, first the inverted TDI bit, then the TMS bit, and last the TDO bit, which the target drives back. The adapter rebuilds TDI and TMS from the first two slots and gives the TAP a single advance strobe when the third slot ends. During that third slot it enables the data-wire driver with the TAP's TDO.

When the mode input is low, the link is in plain 4-wire operation. Every rising link clock edge then produces an advance strobe, and the 4-wire TDI and TMS inputs pass straight to the TAP. The mode input comes from a separate escape and activation tracker. The link clock and data wire arrive already synchronised to the system clock. Edges are detected by comparing the link clock with its value one system clock earlier.

Top module: `tslot_scan_bridge`

## Requirements
- R1: In 4-wire mode (`scan_mode`=0), every rising edge of `lclk` gives exactly one `tap_step` pulse, and `tap_tdi`/`tap_tms` equal `tdi_4w`/`tms_4w`.
- R2: `tap_step` lasts one system clock. It is high in the system clock cycle in which `lclk` is first seen high after being low. A falling edge or a held level never produces it.
- R3: In scan mode (`scan_mode`=1), the slot counter steps through 1, 2, 0, 1, 2, 0 … on rising `lclk` edges. `tap_step` is pulsed only on the edge that ends slot 2, so a steady run gives one step per three edges.
- R4: The edge that ends slot 0 latches the inverse of `dio_in` as TDI. A wire value of 0 gives TDI=1.
- R5: The edge that ends slot 1 latches `dio_in` as TMS.
- R6: In scan mode, `tap_tdi`/`tap_tms` show the latched values, and these are what the TAP sees at the slot-2 step.
- R7: `dio_oe` is 1 exactly while in scan mode and in slot 2. While it is 1, `dio_out` equals `tap_tdo`. At all other times `dio_oe`=0 and `dio_out`=0.
- R8: When scan mode is entered, the counter sits at slot 1, so the first edge is a TMS slot. The latched TDI and TMS read 0 until a slot loads them.
- R9: When `scan_mode` falls, `dio_oe` drops within one system clock and the counter returns to slot 1. On re-entry the next edge is again treated as a TMS slot.
- R10: After reset, `tap_step`=0 and `dio_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_mode | input | 1 | 1 = three-slot scan format, 0 = 4-wire pass-through |
| lclk | input | 1 | Synchronised link clock |
| dio_in | input | 1 | Synchronised data wire input |
| tdi_4w | input | 1 | TDI pin used in 4-wire mode |
| tms_4w | input | 1 | TMS pin used in 4-wire mode |
| tap_tdo | input | 1 | TDO from the TAP |
| tap_tdi | output | 1 | TDI presented to the TAP |
| tap_tms | output | 1 | TMS presented to the TAP |
| tap_step | output | 1 | One-cycle advance strobe for the TAP |
| dio_oe | output | 1 | Data-wire output enable |
| dio_out | output | 1 | Data-wire drive value |

## Verification
The scan format is swept over all eight combinations of TDI, TMS and TDO in back-to-back packets. This separates an inverted TDI from a straight one, a TMS taken from the wrong slot, and a TDO that is driven in the wrong slot or not driven at all. A partial first packet after entry shows whether the counter starts at the TMS slot. Dropping the mode in the middle of slot 2 and then re-entering shows whether the output enable is released and the counter is reset. The 4-wire sweep over TDI and TMS, with long high and low holds on the link clock, shows whether pass-through works and whether only rising edges make a strobe.

// File: rtl/tslot_scan_bridge.sv
module tslot_scan_bridge (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic lclk,
  input  logic dio_in,
  input  logic tdi_4w,
  input  logic tms_4w,
  input  logic tap_tdo,
  output logic tap_tdi,
  output logic tap_tms,
  output logic tap_step,
  output logic dio_oe,
  output logic dio_out
);
  typedef enum logic [1:0] {SL_TDI = 2'd0, SL_TMS = 2'd1, SL_TDO = 2'd2} slot_t;

  logic  lclk_q;
  logic  rise;
  slot_t slot;
  logic  tdi_q, tms_q;

  assign rise = lclk & ~lclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lclk_q <= 1'b0;
    else        lclk_q <= lclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !scan_mode) begin
      slot  <= SL_TMS;
      tdi_q <= 1'b0;
      tms_q <= 1'b0;
    end else if (rise) begin
      unique case (slot)
        SL_TDI: begin
          tdi_q <= ~dio_in;
          slot  <= SL_TMS;
        end
        SL_TMS: begin
          tms_q <= dio_in;
          slot  <= SL_TDO;
        end
        default: slot <= SL_TDI;
      endcase
    end
  end

  assign tap_step = rise & (~scan_mode | (slot == SL_TDO));
  assign tap_tdi  = scan_mode ? tdi_q : tdi_4w;
  assign tap_tms  = scan_mode ? tms_q : tms_4w;
  assign dio_oe   = scan_mode & (slot == SL_TDO);
  assign dio_out  = dio_oe & tap_tdo;
endmodule

module tslot_scan_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic scan_mode,
  input logic lclk,
  input logic tap_tdo,
  input logic tap_step,
  input logic dio_oe,
  input logic dio_out
);
  assert_step_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_step |=> !tap_step);

  assert_step_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tap_step |-> (lclk && !$past(lclk)));

  assert_scan_step_in_slot2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && tap_step) |-> dio_oe);

  assert_oe_release_after_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && tap_step) |=> !dio_oe);

  assert_oe_only_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> scan_mode);

  assert_drive_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> (dio_out == tap_tdo));

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dio_oe |-> !dio_out);
endmodule

bind tslot_scan_bridge tslot_scan_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .lclk(lclk),
  .tap_tdo(tap_tdo), .tap_step(tap_step), .dio_oe(dio_oe), .dio_out(dio_out)
);

// File: tb/tslot_scan_bridge_tb.sv
module tslot_scan_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_mode = 1'b0, lclk = 1'b0, dio_in = 1'b0;
  logic tdi_4w = 1'b0, tms_4w = 1'b0, tap_tdo = 1'b0;
  logic tap_tdi, tap_tms, tap_step, dio_oe, dio_out;

  int n_chk = 0, n_bad = 0, n_step = 0;
  logic cap_tdi = 1'b0, cap_tms = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tslot_scan_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .lclk(lclk),
    .dio_in(dio_in), .tdi_4w(tdi_4w), .tms_4w(tms_4w), .tap_tdo(tap_tdo),
    .tap_tdi(tap_tdi), .tap_tms(tap_tms), .tap_step(tap_step),
    .dio_oe(dio_oe), .dio_out(dio_out)
  );

  always @(negedge clk) if (rst_n && tap_step) begin
    n_step  = n_step + 1;
    cap_tdi = tap_tdi;
    cap_tms = tap_tms;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic link_edge(input logic d);
    dio_in = d;
    lclk   = 1'b0;
    tick(2);
    lclk = 1'b1;
    tick(3);
    lclk = 1'b0;
    tick(1);
  endtask

  task automatic scan_packet(input logic ti, input logic tm, input logic to);
    int s0;
    s0 = n_step;
    link_edge(~ti);
    chk(dio_oe == 1'b0, "R7 oe after slot0", int'(dio_oe), 0);
    link_edge(tm);
    chk(n_step == s0, "R3 no step in slots 0/1", n_step - s0, 0);
    tap_tdo = to;
    tick(1);
    chk(dio_oe == 1'b1, "R7 oe in slot2", int'(dio_oe), 1);
    chk(dio_out == to, "R7 drive value", int'(dio_out), int'(to));
    link_edge(1'b0);
    chk(n_step == s0 + 1, "R3 one step per packet", n_step - s0, 1);
    chk(cap_tdi == ti, "R4 inverted tdi", int'(cap_tdi), int'(ti));
    chk(cap_tms == tm, "R5 tms slot", int'(cap_tms), int'(tm));
    chk(tap_tdi == ti && tap_tms == tm, "R6 latched outputs", {tap_tdi, tap_tms}, {ti, tm});
    chk(dio_oe == 1'b0, "R7 oe after slot2", int'(dio_oe), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(tap_step == 1'b0 && dio_oe == 1'b0, "R10 reset outputs", {tap_step, dio_oe}, 0);

    // 4-wire sweep
    for (int k = 0; k < 4; k++) begin
      tdi_4w = k[1];
      tms_4w = k[0];
      s0 = n_step;
      link_edge(1'b0);
      chk(n_step == s0 + 1, "R1 step per edge", n_step - s0, 1);
      chk(cap_tdi == k[1] && cap_tms == k[0], "R1 direct tdi/tms",
          {cap_tdi, cap_tms}, k);
      chk(dio_oe == 1'b0 && dio_out == 1'b0, "R7 no drive in 4-wire", {dio_oe, dio_out}, 0);
    end
    s0 = n_step;
    lclk = 1'b1;
    tick(8);
    lclk = 1'b0;
    tick(8);
    chk(n_step == s0 + 1, "R2 one step over long high and low", n_step - s0, 1);

    // entry: first edge is TMS slot
    scan_mode = 1'b1;
    tick(1);
    chk(dio_oe == 1'b0, "R8 entry slot is not slot2", int'(dio_oe), 0);
    chk(tap_tdi == 1'b0 && tap_tms == 1'b0, "R8 latches cleared", {tap_tdi, tap_tms}, 0);
    s0 = n_step;
    link_edge(1'b1);
    chk(dio_oe == 1'b1, "R8 after one edge in slot2", int'(dio_oe), 1);
    link_edge(1'b0);
    chk(n_step == s0 + 1, "R8 partial packet steps", n_step - s0, 1);
    chk(cap_tms == 1'b1 && cap_tdi == 1'b0, "R8 partial packet values",
        {cap_tdi, cap_tms}, 1);

    for (int k = 0; k < 8; k++) scan_packet(k[2], k[1], k[0]);

    // leave mid slot 2
    link_edge(1'b1);
    link_edge(1'b1);
    chk(dio_oe == 1'b1, "R9 in slot2 before exit", int'(dio_oe), 1);
    scan_mode = 1'b0;
    tick(1);
    chk(dio_oe == 1'b0, "R9 oe dropped", int'(dio_oe), 0);
    scan_mode = 1'b1;
    tick(1);
    s0 = n_step;
    link_edge(1'b0);
    chk(n_step == s0 && dio_oe == 1'b1, "R9 re-entry at tms slot", n_step - s0, 0);
    link_edge(1'b0);
    chk(n_step == s0 + 1, "R3 step at slot2 after re-entry", n_step - s0, 1);
    scan_packet(1'b1, 1'b1, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule